// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block collects interrupt requests from a configurable number of devices and decides whether the processor must be interrupted. Each device contributes an enable bit, a ready bit, a 3-bit urgency level and an 8-bit vector. A device requests service only while both its enable and its ready bits are set.

Among all requesting devices, the arbiter selects the one with the highest level. When two or more share that level, the lowest device index wins. The winner's level is then compared with the level of the running program, taken from bits [10:8] of a 16-bit status word. The interrupt line is raised only if the winner is strictly more urgent than the program.

The winner's vector, level and index leave the block through a register stage, one clock after the inputs were sampled. The processor uses them to index its interrupt vector table, and the device side uses them to identify the accepted source.

Top module: `vec_irq_arbiter`

## Requirements
- R1: A device counts as requesting only when its enable bit and its ready bit are both 1; a device with either bit at 0 has no effect on any output.
- R2: Levels are 3-bit unsigned values, 0 lowest and 7 highest, and the requesting device with the highest level is selected.
- R3: When several requesting devices share the highest level, the one with the lowest index is selected.
- R4: `irq_int` is 1 only when a request is selected and its level is strictly greater than status bits [10:8]; an equal level does not raise it.
- R5: A selected request at level 0 never raises `irq_int`.
- R6: Whenever any request is present, `irq_vector`, `irq_level` and `irq_winner` give the selected device's 8-bit vector, its level and its index, whether or not `irq_int` is raised.
- R7: With no request present, `irq_int`, `irq_vector`, `irq_level` and `irq_winner` are all 0.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R9: Driving `rst_n` low forces all outputs to 0 at once, and they stay 0 until the reset release has passed the internal synchronizer.
- R10: Status bits outside [10:8] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_enable | input | N_SRC | Per-device permission to request |
| src_ready | input | N_SRC | Per-device service-wanted flag |
| src_level | input | N_SRC*3 | Packed levels, device i at bits [3i+2:3i] |
| src_vector | input | N_SRC*8 | Packed vectors, device i at bits [8i+7:8i] |
| status | input | 16 | Running program status word; level in bits [10:8] |
| irq_int | output | 1 | Interrupt to the processor |
| irq_vector | output | 8 | Vector of the selected device |
| irq_level | output | 3 | Level of the selected device |
| irq_winner | output | 3 | Index of the selected device |

## Verification
The selection is tried with a single request, with requests at distinct levels spread across the index range, and with equal-level clusters. These cases separate picking by level from picking by position and show which way ties break. The comparison is probed at a level one below the program level, at an equal level and at level 0 against a zero program level, which exposes an off-by-one or a non-strict compare. Requests with only one of enable or ready set, and status words with every bit outside [10:8] set, show whether gating and field extraction are wired correctly. An input change is observed before and after a single clock edge to pin the latency.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned DEF_LVL_W    = 3;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_STAT_W   = 16;
  localparam int unsigned DEF_STAT_LSB = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] ready,
  output logic [N_SRC-1:0] req
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign req[g] = enable[g] & ready[g];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] level_flat,
  input  logic [N_SRC*VEC_W-1:0] vector_flat,
  output logic                   any,
  output logic [LVL_W-1:0]       best_lvl,
  output logic [VEC_W-1:0]       best_vec,
  output logic [IDX_W-1:0]       best_idx
);
  logic [LVL_W-1:0] lvl_a [N_SRC];
  logic [VEC_W-1:0] vec_a [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign lvl_a[g] = level_flat[g*LVL_W +: LVL_W];
    assign vec_a[g] = vector_flat[g*VEC_W +: VEC_W];
  end

  // Scan upward; only a strictly higher level displaces the holder,
  // so the lowest index keeps a tie.
  always_comb begin
    any      = 1'b0;
    best_lvl = '0;
    best_vec = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!any || (lvl_a[i] > best_lvl))) begin
        any      = 1'b1;
        best_lvl = lvl_a[i];
        best_vec = vec_a[i];
        best_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [VEC_W-1:0] win_vec,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] run_lvl,
  output logic             int_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [IDX_W-1:0] idx_q
);
  logic             int_d;
  logic [VEC_W-1:0] vec_d;
  logic [LVL_W-1:0] lvl_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    int_d = any && (win_lvl > run_lvl);
    vec_d = any ? win_vec : '0;
    lvl_d = any ? win_lvl : '0;
    idx_d = any ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
      idx_q <= '0;
    end else begin
      int_q <= int_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned LVL_W    = DEF_LVL_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned STAT_W   = DEF_STAT_W,
  parameter int unsigned STAT_LSB = DEF_STAT_LSB,
  localparam int unsigned IDX_W   = idx_width(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_enable,
  input  logic [N_SRC-1:0]       src_ready,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic [N_SRC*VEC_W-1:0] src_vector,
  input  logic [STAT_W-1:0]      status,
  output logic                   irq_int,
  output logic [VEC_W-1:0]       irq_vector,
  output logic [LVL_W-1:0]       irq_level,
  output logic [IDX_W-1:0]       irq_winner
);
  logic             rst_q_n;
  logic [N_SRC-1:0] req;
  logic             any;
  logic [LVL_W-1:0] win_lvl;
  logic [VEC_W-1:0] win_vec;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] run_lvl;
  logic             status_unused;

  assign run_lvl       = status[STAT_LSB +: LVL_W];
  assign status_unused = ^status;

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  irq_req_gate #(.N_SRC(N_SRC)) u_gate (
    .enable (src_enable),
    .ready  (src_ready),
    .req    (req)
  );

  irq_prio_pick #(
    .N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
  ) u_pick (
    .req         (req),
    .level_flat  (src_level),
    .vector_flat (src_vector),
    .any         (any),
    .best_lvl    (win_lvl),
    .best_vec    (win_vec),
    .best_idx    (win_idx)
  );

  irq_out_stage #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .any     (any),
    .win_lvl (win_lvl),
    .win_vec (win_vec),
    .win_idx (win_idx),
    .run_lvl (run_lvl),
    .int_q   (irq_int),
    .vec_q   (irq_vector),
    .lvl_q   (irq_level),
    .idx_q   (irq_winner)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned STAT_LSB = 8,
  parameter int unsigned IDX_W    = 3
) (
  input logic                   clk,
  input logic                   rst_q_n,
  input logic [N_SRC-1:0]       src_enable,
  input logic [N_SRC-1:0]       src_ready,
  input logic [N_SRC*LVL_W-1:0] src_level,
  input logic [N_SRC*VEC_W-1:0] src_vector,
  input logic [STAT_W-1:0]      status,
  input logic                   irq_int,
  input logic [VEC_W-1:0]       irq_vector,
  input logic [LVL_W-1:0]       irq_level,
  input logic [IDX_W-1:0]       irq_winner
);
  logic                   armed;
  logic [N_SRC-1:0]       prev_req;
  logic [N_SRC*LVL_W-1:0] prev_lvl;
  logic [N_SRC*VEC_W-1:0] prev_vec;
  logic [LVL_W-1:0]       prev_run;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      armed    <= 1'b0;
      prev_req <= '0;
      prev_lvl <= '0;
      prev_vec <= '0;
      prev_run <= '0;
    end else begin
      armed    <= 1'b1;
      prev_req <= src_enable & src_ready;
      prev_lvl <= src_level;
      prev_vec <= src_vector;
      prev_run <= status[STAT_LSB +: LVL_W];
    end
  end

  p_int_outranks_r4: assert property (@(posedge clk) disable iff (!armed)
    irq_int |-> (irq_level > prev_run));

  p_outrank_raises_r4: assert property (@(posedge clk) disable iff (!armed)
    ((|prev_req) && (irq_level > prev_run)) |-> irq_int);

  p_level0_quiet_r5: assert property (@(posedge clk) disable iff (!armed)
    irq_int |-> (irq_level != '0));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!armed)
    !(|prev_req) |-> (!irq_int && irq_vector == '0 && irq_level == '0 && irq_winner == '0));

  p_winner_requests_r1: assert property (@(posedge clk) disable iff (!armed)
    (|prev_req) |-> prev_req[irq_winner]);

  p_winner_fields_r6: assert property (@(posedge clk) disable iff (!armed)
    (|prev_req) |-> (irq_vector == prev_vec[irq_winner*VEC_W +: VEC_W] &&
                     irq_level  == prev_lvl[irq_winner*LVL_W +: LVL_W]));
endmodule

bind vec_irq_arbiter irq_arb_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
  .STAT_W(STAT_W), .STAT_LSB(STAT_LSB), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .src_enable (src_enable),
  .src_ready  (src_ready),
  .src_level  (src_level),
  .src_vector (src_vector),
  .status     (status),
  .irq_int    (irq_int),
  .irq_vector (irq_vector),
  .irq_level  (irq_level),
  .irq_winner (irq_winner)
);

// File: tb/vec_irq_arbiter_tb.sv
`timescale 1ns/1ps
module vec_irq_arbiter_tb;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] en;
  logic [N-1:0] rdy;
  logic [N*3-1:0] lvl_f;
  logic [N*8-1:0] vec_f;
  logic [15:0]  stat;
  logic         o_int;
  logic [7:0]   o_vec;
  logic [2:0]   o_lvl;
  logic [2:0]   o_idx;

  int n_tests = 0;
  int n_fail  = 0;

  vec_irq_arbiter #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_enable(en), .src_ready(rdy),
    .src_level(lvl_f), .src_vector(vec_f), .status(stat),
    .irq_int(o_int), .irq_vector(o_vec), .irq_level(o_lvl), .irq_winner(o_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic ei, input logic [7:0] ev,
                     input logic [2:0] el, input logic [2:0] ex);
    n_tests++;
    if (o_int !== ei || o_vec !== ev || o_lvl !== el || o_idx !== ex) begin
      n_fail++;
      $display("FAIL %s actual int=%0b vec=%02h lvl=%0d idx=%0d expected int=%0b vec=%02h lvl=%0d idx=%0d",
               tag, o_int, o_vec, o_lvl, o_idx, ei, ev, el, ex);
    end
  endtask

  task automatic clear_all();
    en = '0; rdy = '0; lvl_f = '0; vec_f = '0; stat = '0;
  endtask

  task automatic set_dev(input int i, input logic e, input logic r,
                         input logic [2:0] l, input logic [7:0] v);
    en[i] = e; rdy[i] = r;
    lvl_f[i*3 +: 3] = l;
    vec_f[i*8 +: 8] = v;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_reset();
    clear_all();
    set_dev(1, 1, 1, 3'd6, 8'h61);
    rst_n = 1'b0;
    step();
    chk("R9 held in reset", 0, 8'h00, 3'd0, 3'd0);
    rst_n = 1'b1;
    step();
    chk("R9 synchronizer still holds", 0, 8'h00, 3'd0, 3'd0);
    repeat (3) step();
    chk("R9 live after release", 1, 8'h61, 3'd6, 3'd1);
    #3 rst_n = 1'b0;
    #1 chk("R9 async assertion clears", 0, 8'h00, 3'd0, 3'd0);
    step();
    rst_n = 1'b1;
    repeat (4) step();
    clear_all();
    step(); step();
  endtask

  task automatic t_idle_and_gate();
    clear_all();
    step(); step();
    chk("R7 no requests", 0, 8'h00, 3'd0, 3'd0);
    set_dev(4, 0, 1, 3'd7, 8'hE4);
    set_dev(6, 1, 0, 3'd7, 8'hE6);
    step(); step();
    chk("R1 half-set devices ignored", 0, 8'h00, 3'd0, 3'd0);
    set_dev(2, 1, 1, 3'd3, 8'h23);
    step(); step();
    chk("R1 only gated device wins", 1, 8'h23, 3'd3, 3'd2);
  endtask

  task automatic t_highest();
    clear_all();
    set_dev(1, 1, 1, 3'd3, 8'hA1);
    set_dev(6, 1, 1, 3'd6, 8'hB6);
    set_dev(3, 1, 1, 3'd5, 8'hC3);
    stat = 16'h0200;
    step(); step();
    chk("R2 highest level among three", 1, 8'hB6, 3'd6, 3'd6);
    set_dev(0, 1, 1, 3'd7, 8'h70);
    step(); step();
    chk("R2 index 0 at level 7 wins", 1, 8'h70, 3'd7, 3'd0);
  endtask

  task automatic t_tie();
    clear_all();
    set_dev(7, 1, 1, 3'd5, 8'h77);
    set_dev(4, 1, 1, 3'd5, 8'h44);
    set_dev(2, 1, 1, 3'd5, 8'h22);
    set_dev(1, 1, 1, 3'd4, 8'h11);
    step(); step();
    chk("R3 tie to lowest index", 1, 8'h22, 3'd5, 3'd2);
    set_dev(2, 0, 1, 3'd5, 8'h22);
    step(); step();
    chk("R3 tie next lowest", 1, 8'h44, 3'd5, 3'd4);
  endtask

  task automatic t_compare();
    clear_all();
    set_dev(0, 1, 1, 3'd4, 8'h0D);
    stat = 16'h0400;
    step(); step();
    chk("R4 equal level no int", 0, 8'h0D, 3'd4, 3'd0);
    stat = 16'h0300;
    step(); step();
    chk("R4 one above raises int", 1, 8'h0D, 3'd4, 3'd0);
    set_dev(0, 1, 1, 3'd7, 8'h0D);
    stat = 16'h0700;
    step(); step();
    chk("R4 level 7 vs 7 no int", 0, 8'h0D, 3'd7, 3'd0);
  endtask

  task automatic t_level0();
    clear_all();
    set_dev(3, 1, 1, 3'd0, 8'h33);
    step(); step();
    chk("R5 level 0 never interrupts", 0, 8'h33, 3'd0, 3'd3);
    chk("R6 fields shown without int", 0, 8'h33, 3'd0, 3'd3);
  endtask

  task automatic t_status_bits();
    clear_all();
    set_dev(5, 1, 1, 3'd2, 8'h5A);
    stat = 16'hF8FF;
    step(); step();
    chk("R10 bits outside field ignored", 1, 8'h5A, 3'd2, 3'd5);
    stat = 16'h0700;
    step(); step();
    chk("R10 field alone blocks", 0, 8'h5A, 3'd2, 3'd5);
  endtask

  task automatic t_latency();
    clear_all();
    set_dev(6, 1, 1, 3'd1, 8'h66);
    step(); step();
    chk("R8 baseline", 1, 8'h66, 3'd1, 3'd6);
    set_dev(3, 1, 1, 3'd6, 8'h36);
    #1 chk("R8 no change before edge", 1, 8'h66, 3'd1, 3'd6);
    step();
    chk("R8 change after one edge", 1, 8'h36, 3'd6, 3'd3);
    clear_all();
    step();
    chk("R8 clears after one edge", 0, 8'h00, 3'd0, 3'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_all();
    rst_n = 1'b0;
    do_reset();
    t_reset();
    t_idle_and_gate();
    t_highest();
    t_tie();
    t_compare();
    t_level0();
    t_status_bits();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule